// File: doc/BRIEF.md
# Protection Key Check Cache

This block holds a small, fully associative set of protection key entries and judges every address-translation reference against them. Each entry carries a key tag and three disable bits, one for each access type: instruction fetch, data read and data write. Access is granted by domain membership rather than by privilege level. The key tagged on a page selects an entry, and that entry's disable bit for the access in progress can veto an access the page rights would otherwise allow.

Software fills the entries through a write port: it names an index and supplies all five fields. Software also chooses which entry to overwrite, so the block has no replacement policy. A lookup presents a key tag, an access type and a flag saying whether the page rights allow the access. One cycle later the block returns exactly one of three outcomes, or none of them. The outcomes are allow, a permission fault (a key matched and vetoed the access) and a miss fault (no valid entry holds the key). On a miss, software inserts the key and retries. A global enable turns key checking off. While it is off, the page-rights flag alone decides the result.

Because the same key can be loaded with different disable bits for different processes, one shared page can be writable by one process and read-only for another.

Top module: `pkey_check_cache`

## Requirements
- R1: After reset, all result outputs are 0 and every entry is invalid, so an enabled lookup of any key reports a miss fault.
- R2: A write strobe loads all five fields into the entry at `wr_idx` on the next rising edge. A lookup presented in the same cycle as the write is judged against the contents from before the write, and a lookup in any later cycle sees the new contents.
- R3: `clear_all` sets every valid bit to 0 on the next rising edge. It takes precedence over a write in the same cycle, so that written entry also ends up invalid.
- R4: With `chk_enable` at 0, `res_allow` equals the page-rights flag and neither key fault is ever raised.
- R5: With checking enabled and no valid entry holding the key, the miss fault is raised whatever the page-rights flag is. An entry whose valid bit is 0 never matches.
- R6: The access code selects the disable bit that applies: 0 is a fetch and uses execute-disable, 1 is a read and uses read-disable, and 2 and 3 are writes and use write-disable. If the selected bit of the matching entry is set, the permission fault is raised even when the page rights allow the access.
- R7: When a matching entry's selected disable bit is clear, `res_allow` equals the page-rights flag. A page-rights denial therefore raises no key fault.
- R8: When several valid entries hold the same key, the entry with the lowest index alone decides the result.
- R9: `res_valid` is 1 exactly in the cycle after a cycle with `lk_valid` at 1. The three result outputs are 0 whenever `res_valid` is 0.
- R10: At most one of `res_allow`, `res_perm_fault` and `res_miss_fault` is 1 at any time.
- R11: One key can carry different rights at different times. With key 0xA loaded with read-disable and write-disable both clear, writes are allowed. After the same entry is reloaded with write-disable set, writes take a permission fault and reads are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_all | input | 1 | Invalidates every entry on the next edge |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | IDX_W (4) | Index of the entry to write |
| wr_valid | input | 1 | Valid bit to store |
| wr_wdis | input | 1 | Write-disable bit to store |
| wr_rdis | input | 1 | Read-disable bit to store |
| wr_xdis | input | 1 | Execute-disable bit to store |
| wr_key | input | KEY_W (24) | Key tag to store |
| chk_enable | input | 1 | Global key-checking enable |
| lk_valid | input | 1 | Lookup strobe |
| lk_key | input | KEY_W (24) | Key tag of the referenced page |
| lk_acc | input | 2 | Access type: 0 fetch, 1 read, 2 or 3 write |
| lk_page_ok | input | 1 | Page rights allow this access |
| res_valid | output | 1 | Result qualifier, one cycle after `lk_valid` |
| res_allow | output | 1 | Access allowed |
| res_perm_fault | output | 1 | Matching key vetoed the access |
| res_miss_fault | output | 1 | No valid entry holds the key |

## Verification
The risky overlap is a lookup and a write to the same entry in the same cycle, and likewise a clear-all together with a write. The bench provokes the first by writing a new key into an entry while looking that key up in the same cycle. It expects the miss that the old contents give, and then, one cycle later, the new outcome. For the second, it strobes `clear_all` and a write together. It then requires that both the written key and an older key report misses.

// File: rtl/pkey_pkg.sv
`timescale 1ns/1ps
package pkey_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_WRALT = 2'd3
    } acc_e;

    typedef struct packed {
        logic valid;
        logic wdis;
        logic rdis;
        logic xdis;
    } perm_t;

    typedef struct packed {
        logic allow;
        logic perm_fault;
        logic miss_fault;
    } verdict_t;

    localparam verdict_t VERDICT_NONE = '{allow: 1'b0, perm_fault: 1'b0, miss_fault: 1'b0};

    // disable bit that governs the given access type
    function automatic logic veto_bit(perm_t p, acc_e a);
        logic b;
        case (a)
            ACC_FETCH: b = p.xdis;
            ACC_READ:  b = p.rdis;
            default:   b = p.wdis;
        endcase
        return b;
    endfunction

    function automatic verdict_t judge(logic en, logic hit, logic veto, logic page_ok);
        verdict_t v;
        v = VERDICT_NONE;
        if (!en) begin
            v.allow = page_ok;
        end else if (!hit) begin
            v.miss_fault = 1'b1;
        end else if (veto) begin
            v.perm_fault = 1'b1;
        end else begin
            v.allow = page_ok;
        end
        return v;
    endfunction

endpackage

// File: rtl/pkey_entry_bank.sv
`timescale 1ns/1ps
module pkey_entry_bank
    import pkey_pkg::*;
#(
    parameter int NUM   = 16,
    parameter int KEY_W = 24,
    parameter int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear_all,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  perm_t                       wr_perm,
    input  logic [KEY_W-1:0]            wr_key,
    output perm_t [NUM-1:0]             perm_q,
    output logic  [NUM-1:0][KEY_W-1:0]  key_q
);

    for (genvar i = 0; i < NUM; i++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                perm_q[i] <= '0;
                key_q[i]  <= '0;
            end else begin
                if (sel) begin
                    perm_q[i] <= wr_perm;
                    key_q[i]  <= wr_key;
                end
                if (clear_all) begin
                    perm_q[i].valid <= 1'b0;
                end
            end
        end
    end

    logic [NUM-1:0] valid_vec;
    always_comb begin
        for (int i = 0; i < NUM; i++) valid_vec[i] = perm_q[i].valid;
    end

    // R3
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clear_all |=> ($countones(valid_vec) == 0));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clear_all && (int'(wr_idx) < NUM)) |=>
            (perm_q[$past(wr_idx)] == $past(wr_perm) && key_q[$past(wr_idx)] == $past(wr_key)));

endmodule

// File: rtl/pkey_match.sv
`timescale 1ns/1ps
module pkey_match
    import pkey_pkg::*;
#(
    parameter int NUM   = 16,
    parameter int KEY_W = 24
) (
    input  perm_t [NUM-1:0]             perm_q,
    input  logic  [NUM-1:0][KEY_W-1:0]  key_q,
    input  logic  [KEY_W-1:0]           lk_key,
    output logic                        hit,
    output perm_t                       sel_perm
);

    logic [NUM-1:0] hit_vec;

    for (genvar i = 0; i < NUM; i++) begin : g_cmp
        assign hit_vec[i] = perm_q[i].valid && (key_q[i] == lk_key);
    end

    // lowest index wins: scan from the top so lower entries overwrite
    always_comb begin
        sel_perm = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel_perm = perm_q[i];
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/pkey_verdict.sv
`timescale 1ns/1ps
module pkey_verdict
    import pkey_pkg::*;
(
    input  logic        chk_enable,
    input  logic        hit,
    input  perm_t       sel_perm,
    input  logic [1:0]  acc,
    input  logic        page_ok,
    output verdict_t    verdict
);

    logic veto;

    always_comb begin
        veto    = veto_bit(sel_perm, acc_e'(acc));
        verdict = judge(chk_enable, hit, veto, page_ok);
    end

endmodule

// File: rtl/pkey_check_cache.sv
`timescale 1ns/1ps
module pkey_check_cache
    import pkey_pkg::*;
#(
    parameter int NUM   = 16,
    parameter int KEY_W = 24,
    parameter int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_all,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_wdis,
    input  logic              wr_rdis,
    input  logic              wr_xdis,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic              chk_enable,
    input  logic              lk_valid,
    input  logic [KEY_W-1:0]  lk_key,
    input  logic [1:0]        lk_acc,
    input  logic              lk_page_ok,
    output logic              res_valid,
    output logic              res_allow,
    output logic              res_perm_fault,
    output logic              res_miss_fault
);

    perm_t                      wr_perm;
    perm_t [NUM-1:0]            perm_q;
    logic  [NUM-1:0][KEY_W-1:0] key_q;
    logic                       hit;
    perm_t                      sel_perm;
    verdict_t                   verdict_d;
    verdict_t                   verdict_q;

    assign wr_perm = '{valid: wr_valid, wdis: wr_wdis, rdis: wr_rdis, xdis: wr_xdis};

    pkey_entry_bank #(.NUM(NUM), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .clear_all (clear_all),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_perm   (wr_perm),
        .wr_key    (wr_key),
        .perm_q    (perm_q),
        .key_q     (key_q)
    );

    pkey_match #(.NUM(NUM), .KEY_W(KEY_W)) u_match (
        .perm_q   (perm_q),
        .key_q    (key_q),
        .lk_key   (lk_key),
        .hit      (hit),
        .sel_perm (sel_perm)
    );

    pkey_verdict u_verdict (
        .chk_enable (chk_enable),
        .hit        (hit),
        .sel_perm   (sel_perm),
        .acc        (lk_acc),
        .page_ok    (lk_page_ok),
        .verdict    (verdict_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            verdict_q <= VERDICT_NONE;
        end else begin
            res_valid <= lk_valid;
            verdict_q <= lk_valid ? verdict_d : VERDICT_NONE;
        end
    end

    assign res_allow      = verdict_q.allow;
    assign res_perm_fault = verdict_q.perm_fault;
    assign res_miss_fault = verdict_q.miss_fault;

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_allow, res_perm_fault, res_miss_fault}));

    // R9
    result_follows_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!res_valid && !res_allow && !res_perm_fault && !res_miss_fault));

    // R4
    keys_off_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !chk_enable) |=>
            (!res_perm_fault && !res_miss_fault && res_allow == $past(lk_page_ok)));

endmodule

// File: tb/pkey_check_cache_test.sv
`timescale 1ns/1ps
module pkey_check_cache_test;

    localparam int NUM   = 16;
    localparam int KEY_W = 24;
    localparam int IDX_W = $clog2(NUM);
    localparam int WATCHDOG_CYC = 5000;

    logic              clk = 1'b0;
    logic              rst;
    logic              clear_all;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic              wr_valid, wr_wdis, wr_rdis, wr_xdis;
    logic [KEY_W-1:0]  wr_key;
    logic              chk_enable;
    logic              lk_valid;
    logic [KEY_W-1:0]  lk_key;
    logic [1:0]        lk_acc;
    logic              lk_page_ok;
    logic              res_valid, res_allow, res_perm_fault, res_miss_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pkey_check_cache #(.NUM(NUM), .KEY_W(KEY_W)) uut (
        .clk(clk), .rst(rst), .clear_all(clear_all),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_wdis(wr_wdis), .wr_rdis(wr_rdis), .wr_xdis(wr_xdis), .wr_key(wr_key),
        .chk_enable(chk_enable), .lk_valid(lk_valid), .lk_key(lk_key),
        .lk_acc(lk_acc), .lk_page_ok(lk_page_ok),
        .res_valid(res_valid), .res_allow(res_allow),
        .res_perm_fault(res_perm_fault), .res_miss_fault(res_miss_fault)
    );

    // expected result packed as {valid, allow, perm, miss}
    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] got;
        got = {res_valid, res_allow, res_perm_fault, res_miss_fault};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got v/a/p/m=%b expected %b", req, got, exp);
        end
    endtask

    task automatic put_write(input int idx, input logic v, input logic wd,
                             input logic rd, input logic xd, input logic [KEY_W-1:0] k);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = v;
        wr_wdis = wd; wr_rdis = rd; wr_xdis = xd; wr_key = k;
    endtask

    task automatic put_lookup(input logic en, input logic [KEY_W-1:0] k,
                              input logic [1:0] acc, input logic pok);
        chk_enable = en; lk_valid = 1'b1; lk_key = k; lk_acc = acc; lk_page_ok = pok;
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; clear_all = 1'b0; lk_valid = 1'b0;
    endtask

    task automatic write_entry(input int idx, input logic v, input logic wd,
                               input logic rd, input logic xd, input logic [KEY_W-1:0] k);
        @(negedge clk);
        put_write(idx, v, wd, rd, xd, k);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic lookup(input string req, input logic en, input logic [KEY_W-1:0] k,
                          input logic [1:0] acc, input logic pok, input logic [2:0] exp_apm);
        @(negedge clk);
        put_lookup(en, k, acc, pok);
        @(negedge clk);
        idle_inputs();
        check(req, {1'b1, exp_apm});
    endtask

    task automatic t_reset();
        check("R1 reset outputs", 4'b0000);
        lookup("R1 empty after reset", 1'b1, 24'h000005, 2'd1, 1'b1, 3'b001);
        lookup("R1 key zero misses after reset", 1'b1, 24'h000000, 2'd0, 1'b1, 3'b001);
    endtask

    task automatic t_disabled();
        lookup("R4 off page ok", 1'b0, 24'h123456, 2'd2, 1'b1, 3'b100);
        lookup("R4 off page denied", 1'b0, 24'h123456, 2'd2, 1'b0, 3'b000);
    endtask

    task automatic t_miss();
        write_entry(4, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000055);
        lookup("R5 invalid entry ignored", 1'b1, 24'h000055, 2'd1, 1'b1, 3'b001);
        lookup("R5 miss despite page denial", 1'b1, 24'h000077, 2'd0, 1'b0, 3'b001);
    endtask

    task automatic t_types();
        write_entry(5, 1'b1, 1'b0, 1'b0, 1'b1, 24'h000111);
        lookup("R6 fetch vetoed by xd", 1'b1, 24'h000111, 2'd0, 1'b1, 3'b010);
        lookup("R6 read ignores xd", 1'b1, 24'h000111, 2'd1, 1'b1, 3'b100);
        lookup("R6 write ignores xd", 1'b1, 24'h000111, 2'd2, 1'b1, 3'b100);
        write_entry(6, 1'b1, 1'b1, 1'b0, 1'b0, 24'h000333);
        lookup("R6 code 3 is write", 1'b1, 24'h000333, 2'd3, 1'b1, 3'b010);
        lookup("R6 veto with page denied", 1'b1, 24'h000333, 2'd2, 1'b0, 3'b010);
        write_entry(8, 1'b1, 1'b0, 1'b1, 1'b0, 24'h000444);
        lookup("R6 read vetoed by rd", 1'b1, 24'h000444, 2'd1, 1'b1, 3'b010);
        lookup("R7 permitted key page denied", 1'b1, 24'h000444, 2'd2, 1'b0, 3'b000);
        lookup("R7 permitted key page ok", 1'b1, 24'h000444, 2'd0, 1'b1, 3'b100);
    endtask

    task automatic t_priority();
        write_entry(2, 1'b1, 1'b1, 1'b0, 1'b0, 24'h000222);
        write_entry(7, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000222);
        lookup("R8 lowest index decides", 1'b1, 24'h000222, 2'd2, 1'b1, 3'b010);
        write_entry(2, 1'b0, 1'b1, 1'b0, 1'b0, 24'h000222);
        lookup("R8 next entry after invalidate", 1'b1, 24'h000222, 2'd2, 1'b1, 3'b100);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        put_write(9, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000999);
        put_lookup(1'b1, 24'h000999, 2'd1, 1'b1);
        @(negedge clk);
        idle_inputs();
        check("R2 same-cycle lookup sees old", 4'b1001);
        lookup("R2 later lookup sees new", 1'b1, 24'h000999, 2'd1, 1'b1, 3'b100);
    endtask

    task automatic t_clear();
        @(negedge clk);
        clear_all = 1'b1;
        put_write(10, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000AAA);
        @(negedge clk);
        idle_inputs();
        lookup("R3 clear beats write", 1'b1, 24'h000AAA, 2'd1, 1'b1, 3'b001);
        lookup("R3 older entry cleared", 1'b1, 24'h000999, 2'd1, 1'b1, 3'b001);
    endtask

    task automatic t_timing();
        lookup("R9 result one cycle later", 1'b0, 24'h0, 2'd0, 1'b1, 3'b100);
        @(negedge clk);
        check("R9 no strobe quiet", 4'b0000);
        check("R10 single outcome", 4'b0000);
    endtask

    task automatic t_shared();
        write_entry(0, 1'b1, 1'b0, 1'b0, 1'b0, 24'h00000A);
        lookup("R11 producer write allowed", 1'b1, 24'h00000A, 2'd2, 1'b1, 3'b100);
        write_entry(0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h00000A);
        lookup("R11 consumer write faults", 1'b1, 24'h00000A, 2'd2, 1'b1, 3'b010);
        lookup("R11 consumer read allowed", 1'b1, 24'h00000A, 2'd1, 1'b1, 3'b100);
    endtask

    initial begin
        rst = 1'b1; clear_all = 1'b0; wr_en = 1'b0; wr_idx = '0;
        wr_valid = 1'b0; wr_wdis = 1'b0; wr_rdis = 1'b0; wr_xdis = 1'b0; wr_key = '0;
        chk_enable = 1'b0; lk_valid = 1'b0; lk_key = '0; lk_acc = '0; lk_page_ok = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_miss();
        t_types();
        t_priority();
        t_same_cycle();
        t_clear();
        t_timing();
        t_shared();
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(WATCHDOG_CYC * 5.0);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule